// File: doc/BRIEF.md
# Paged Management Register Window

This block decodes a 32-entry space of 16-bit management registers and uses a page register at the top address to switch its upper half between two banks. Addresses 0 to 15 always reach the base bank. Addresses 16 to 30 reach the base bank or the extended bank, depending on the value held in the page register. Address 31 is always the page register.

The register storage for both banks sits outside this block. Each bank gets its own read and write strobes, and all banks share the address and write data. The block holds the page register, chooses which bank an access goes to, and registers the read data from the chosen source.

Top module: `mgmt_page_window`

## Requirements
- R1: After reset the page register holds 0x0000, no strobe is active, `rsp_rdata` is 0x0000, and addresses 16–30 map to the base bank.
- R2: After 0x0001 is written to address 31, accesses to addresses 16–30 raise only `ext_rd`/`ext_wr`, and never `base_rd`/`base_wr`.
- R3: After 0x0000 is written to address 31, accesses to addresses 16–30 raise only `base_rd`/`base_wr` again.
- R4: Accesses to addresses 0–15 raise only the base strobes, whatever value the page register holds.
- R5: Address 31 can be read and written on every page. It raises no bank strobe, and a read returns the last value written to it.
- R6: A page value other than 0x0000 or 0x0001 maps addresses 16–30 to the base bank, and that value still reads back from address 31.
- R7: A page write takes effect from the following cycle. A read of address 31 in the same cycle as the page write returns the old value. An access to addresses 16–30 in that same cycle uses the old page.
- R8: At most one bank's strobes are active in any cycle. Every access to addresses 0–30 activates exactly one bank. When `req_rd` and `req_wr` are both set in one cycle, both go to the same bank.
- R9: `rsp_rdata` changes one cycle after `req_rd`. It then carries the chosen source's value from the read cycle: `base_rdata`, `ext_rdata` or the page register. It holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| req_addr | input | 5 | Register address |
| req_wr | input | 1 | Write enable |
| req_wdata | input | 16 | Write data |
| req_rd | input | 1 | Read enable |
| rsp_rdata | output | 16 | Registered read data, valid the cycle after `req_rd` |
| bank_addr | output | 5 | Address shared by both banks |
| bank_wdata | output | 16 | Write data shared by both banks |
| base_rd | output | 1 | Read strobe to the base bank |
| base_wr | output | 1 | Write strobe to the base bank |
| ext_rd | output | 1 | Read strobe to the extended bank |
| ext_wr | output | 1 | Write strobe to the extended bank |
| base_rdata | input | 16 | Base bank read data for `bank_addr`, same cycle |
| ext_rdata | input | 16 | Extended bank read data for `bank_addr`, same cycle |

## Verification
A page register write and an access to the paged half can fall in the same cycle. The same is true of a page write and a read of the page register itself. The bench forces both cases with directed writes to address 31 that carry `req_rd` and, in the random phase, with back-to-back page flips mixed with accesses to 16–30. Its reference model decides the bank and the expected read data from the page value held before the edge, so a design that applies the new page early shows up as a wrong strobe or wrong data.

// File: rtl/mgmt_pw_pkg.sv
package mgmt_pw_pkg;

    // Which source an access is routed to
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_BASE = 2'd1,
        TGT_EXT  = 2'd2,
        TGT_PAGE = 2'd3
    } tgt_e;

endpackage

// File: rtl/mgmt_page_reg.sv
module mgmt_page_reg #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PAGE_ADDR = 31,
    parameter int EXT_VAL   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] page_val,
    output logic              ext_sel
);

    localparam logic [ADDR_W-1:0] PAGE_A = ADDR_W'(PAGE_ADDR);
    localparam logic [DATA_W-1:0] EXT_V  = DATA_W'(EXT_VAL);

    typedef struct packed {
        logic [DATA_W-1:0] page;
        logic              ext;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_wr && (req_addr == PAGE_A)) begin
            st_d.page = req_wdata;
            st_d.ext  = (req_wdata == EXT_V);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_val = st_q.page;
    assign ext_sel  = st_q.ext;

endmodule

// File: rtl/mgmt_addr_steer.sv
module mgmt_addr_steer
    import mgmt_pw_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int PAGED_LO  = 16,
    parameter int PAGE_ADDR = 31
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              ext_sel,
    output tgt_e              target,
    output logic              base_rd,
    output logic              base_wr,
    output logic              ext_rd,
    output logic              ext_wr
);

    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(PAGED_LO);
    localparam logic [ADDR_W-1:0] PAGE_A = ADDR_W'(PAGE_ADDR);

    logic access;
    logic in_paged;

    always_comb begin
        access   = req_rd || req_wr;
        in_paged = (req_addr >= LO_A) && (req_addr != PAGE_A);
        target   = TGT_NONE;
        if (access) begin
            if (req_addr == PAGE_A) begin
                target = TGT_PAGE;
            end else if (in_paged && ext_sel) begin
                target = TGT_EXT;
            end else begin
                target = TGT_BASE;
            end
        end
        base_rd = req_rd && (target == TGT_BASE);
        base_wr = req_wr && (target == TGT_BASE);
        ext_rd  = req_rd && (target == TGT_EXT);
        ext_wr  = req_wr && (target == TGT_EXT);
    end

endmodule

// File: rtl/mgmt_rdata_mux.sv
module mgmt_rdata_mux
    import mgmt_pw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  tgt_e              target,
    input  logic [DATA_W-1:0] base_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic [DATA_W-1:0] page_val,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_rd) begin
            unique case (target)
                TGT_BASE: st_d.rdata = base_rdata;
                TGT_EXT:  st_d.rdata = ext_rdata;
                TGT_PAGE: st_d.rdata = page_val;
                default:  st_d.rdata = st_q.rdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/mgmt_page_window.sv
module mgmt_page_window
    import mgmt_pw_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PAGED_LO  = 16,
    parameter int PAGE_ADDR = 31,
    parameter int EXT_VAL   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_rd,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              base_rd,
    output logic              base_wr,
    output logic              ext_rd,
    output logic              ext_wr,
    input  logic [DATA_W-1:0] base_rdata,
    input  logic [DATA_W-1:0] ext_rdata
);

    logic [DATA_W-1:0] page_val;
    logic              ext_sel;
    tgt_e              target;

    mgmt_page_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_ADDR (PAGE_ADDR),
        .EXT_VAL   (EXT_VAL)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .page_val  (page_val),
        .ext_sel   (ext_sel)
    );

    mgmt_addr_steer #(
        .ADDR_W    (ADDR_W),
        .PAGED_LO  (PAGED_LO),
        .PAGE_ADDR (PAGE_ADDR)
    ) u_steer (
        .req_addr (req_addr),
        .req_rd   (req_rd),
        .req_wr   (req_wr),
        .ext_sel  (ext_sel),
        .target   (target),
        .base_rd  (base_rd),
        .base_wr  (base_wr),
        .ext_rd   (ext_rd),
        .ext_wr   (ext_wr)
    );

    mgmt_rdata_mux #(
        .DATA_W (DATA_W)
    ) u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_rd     (req_rd),
        .target     (target),
        .base_rdata (base_rdata),
        .ext_rdata  (ext_rdata),
        .page_val   (page_val),
        .rsp_rdata  (rsp_rdata)
    );

    assign bank_addr  = req_addr;
    assign bank_wdata = req_wdata;

endmodule

// File: rtl/mgmt_page_window_chk.sv
module mgmt_page_window_chk #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PAGED_LO  = 16,
    parameter int PAGE_ADDR = 31,
    parameter int EXT_VAL   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_wr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              req_rd,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              base_rd,
    input logic              base_wr,
    input logic              ext_rd,
    input logic              ext_wr,
    input logic [DATA_W-1:0] base_rdata,
    input logic [DATA_W-1:0] ext_rdata
);

    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(PAGED_LO);
    localparam logic [ADDR_W-1:0] PAGE_A = ADDR_W'(PAGE_ADDR);
    localparam logic [DATA_W-1:0] EXT_V  = DATA_W'(EXT_VAL);

    logic acc, paged;
    assign acc   = req_rd || req_wr;
    assign paged = (req_addr >= LO_A) && (req_addr != PAGE_A);

    p_ext_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_wr && (req_addr == PAGE_A) && (req_wdata == EXT_V)) && acc && paged)
        |-> ((ext_rd || ext_wr) && !base_rd && !base_wr));

    p_base_after_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_wr && (req_addr == PAGE_A) && (req_wdata == '0)) && acc && paged)
        |-> ((base_rd || base_wr) && !ext_rd && !ext_wr));

    p_low_half_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_addr < LO_A)) |-> (!ext_rd && !ext_wr && (base_rd || base_wr)));

    p_page_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_addr == PAGE_A)) |-> !(base_rd || base_wr || ext_rd || ext_wr));

    p_page_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_wr && (req_addr == PAGE_A)) && req_rd && (req_addr == PAGE_A))
        |=> (rsp_rdata == $past(req_wdata, 2)));

    p_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({(base_rd || base_wr), (ext_rd || ext_wr)}));

    p_ext_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd |=> (rsp_rdata == $past(ext_rdata)));

    p_base_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        base_rd |=> (rsp_rdata == $past(base_rdata)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> $stable(rsp_rdata));

endmodule

bind mgmt_page_window mgmt_page_window_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGED_LO  (PAGED_LO),
    .PAGE_ADDR (PAGE_ADDR),
    .EXT_VAL   (EXT_VAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_addr   (req_addr),
    .req_wr     (req_wr),
    .req_wdata  (req_wdata),
    .req_rd     (req_rd),
    .rsp_rdata  (rsp_rdata),
    .base_rd    (base_rd),
    .base_wr    (base_wr),
    .ext_rd     (ext_rd),
    .ext_wr     (ext_wr),
    .base_rdata (base_rdata),
    .ext_rdata  (ext_rdata)
);

// File: tb/mgmt_page_window_tb.sv
`timescale 1ns/1ps
module mgmt_page_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  req_addr = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_rd = 1'b0;
    logic [15:0] rsp_rdata;
    logic [4:0]  bank_addr;
    logic [15:0] bank_wdata;
    logic        base_rd, base_wr, ext_rd, ext_wr;
    logic [15:0] base_rdata, ext_rdata;

    // Backing storage outside the block, driven only by its strobes
    logic [15:0] base_mem [32];
    logic [15:0] ext_mem  [32];

    // Reference model
    logic [15:0] m_base [32];
    logic [15:0] m_ext  [32];
    logic [15:0] m_page;

    int n_chk = 0;
    int n_fail = 0;
    logic        pend = 1'b0;
    logic [15:0] pend_exp;
    string       pend_tag;

    always #2.5 clk = ~clk;

    mgmt_page_window u_dut (
        .clk (clk), .rst_n (rst_n), .req_addr (req_addr), .req_wr (req_wr),
        .req_wdata (req_wdata), .req_rd (req_rd), .rsp_rdata (rsp_rdata),
        .bank_addr (bank_addr), .bank_wdata (bank_wdata),
        .base_rd (base_rd), .base_wr (base_wr), .ext_rd (ext_rd), .ext_wr (ext_wr),
        .base_rdata (base_rdata), .ext_rdata (ext_rdata)
    );

    assign base_rdata = base_mem[bank_addr];
    assign ext_rdata  = ext_mem[bank_addr];

    always_ff @(posedge clk) begin
        if (base_wr) base_mem[bank_addr] <= bank_wdata;
        if (ext_wr)  ext_mem[bank_addr]  <= bank_wdata;
    end

    // 0 none, 1 base, 2 ext
    function automatic int exp_bank(input logic [4:0] a, input logic [15:0] pg);
        if (a == 5'd31) return 0;
        if (a < 5'd16)  return 1;
        return (pg == 16'h0001) ? 2 : 1;
    endfunction

    function automatic string bank_tag(input logic [4:0] a, input logic [15:0] pg);
        if (a == 5'd31) return "R5";
        if (a < 5'd16)  return "R4";
        if (pg == 16'h0001) return "R2";
        if (pg == 16'h0000) return "R3";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, inspect strobes, update model
    task automatic cyc(input logic [4:0] a, input logic rd, input logic wr,
                       input logic [15:0] d, input string tag);
        int b;
        string t;
        logic [15:0] ex;
        @(negedge clk);
        if (pend) check(pend_tag, rsp_rdata, pend_exp);
        pend = 1'b0;
        req_addr = a; req_rd = rd; req_wr = wr; req_wdata = d;
        #1;
        b = exp_bank(a, m_page);
        t = (tag != "") ? tag : bank_tag(a, m_page);
        check("R8", 16'($countones({base_rd | base_wr, ext_rd | ext_wr})),
              16'((rd || wr) && b != 0));
        check(t, {12'd0, base_rd, base_wr, ext_rd, ext_wr},
              {12'd0, rd && b == 1, wr && b == 1, rd && b == 2, wr && b == 2});
        if (rd) begin
            ex = (b == 0) ? m_page : (b == 1) ? m_base[a] : m_ext[a];
            pend = 1'b1; pend_exp = ex;
            pend_tag = (tag != "") ? tag : ((b == 0) ? "R5" : "R9");
        end
        if (wr) begin
            if (b == 0) m_page = d;
            else if (b == 1) m_base[a] = d;
            else m_ext[a] = d;
        end
    endtask

    task automatic idle();
        cyc(5'd0, 1'b0, 1'b0, 16'h0, "R9");
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            base_mem[i] = 16'(i * 16'h0101 + 16'h1000);
            ext_mem[i]  = 16'(i * 16'h0303 + 16'h8000);
            m_base[i]   = base_mem[i];
            m_ext[i]    = ext_mem[i];
        end
        m_page = 16'h0000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", rsp_rdata, 16'h0000);
        check("R1", {12'd0, base_rd, base_wr, ext_rd, ext_wr}, 16'h0);
        cyc(5'd31, 1'b1, 1'b0, 16'h0, "R1");
        cyc(5'd20, 1'b1, 1'b0, 16'h0, "R1");
        // R2 select extended
        cyc(5'd31, 1'b0, 1'b1, 16'h0001, "R2");
        cyc(5'd20, 1'b0, 1'b1, 16'hBEEF, "R2");
        cyc(5'd20, 1'b1, 1'b0, 16'h0, "R2");
        cyc(5'd30, 1'b1, 1'b0, 16'h0, "R2");
        // R4 low half on page 1
        cyc(5'd15, 1'b1, 1'b1, 16'h1234, "R4");
        cyc(5'd15, 1'b1, 1'b0, 16'h0, "R4");
        // R7 write and read page in same cycle: old value returned
        cyc(5'd31, 1'b1, 1'b1, 16'h0000, "R7");
        cyc(5'd20, 1'b1, 1'b0, 16'h0, "R3");
        // R7 page write then paged access next cycle; both on write cycle
        cyc(5'd31, 1'b1, 1'b1, 16'h0001, "R7");
        cyc(5'd16, 1'b1, 1'b0, 16'h0, "R7");
        // R6 other page values
        cyc(5'd31, 1'b0, 1'b1, 16'h0005, "R6");
        cyc(5'd20, 1'b1, 1'b0, 16'h0, "R6");
        cyc(5'd31, 1'b1, 1'b0, 16'h0, "R6");
        cyc(5'd31, 1'b0, 1'b1, 16'hFFFF, "R6");
        cyc(5'd25, 1'b1, 1'b1, 16'hA5A5, "R6");
        cyc(5'd31, 1'b1, 1'b0, 16'h0, "R5");
        // R9 hold with no read
        idle();
        idle();
        check("R9", rsp_rdata, 16'hFFFF);
        // Random phase with fixed seed
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]  a;
            logic [15:0] d;
            int r;
            r = int'($urandom_range(0, 9));
            a = 5'($urandom_range(0, 31));
            if (r < 2) a = 5'd31;
            d = 16'($urandom);
            if (a == 5'd31 && r != 1) d = {15'd0, d[0]};
            cyc(a, 1'($urandom), 1'($urandom), d, "");
        end
        idle();
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule